// File: doc/BRIEF.md
# PCI Type 0 Configuration Header

This block holds the 64-byte Type 0 configuration header of a PCI target function. It serves configuration reads and writes addressed by dword index (0 to 15), with per-lane byte enables. Read data comes back one cycle after the read request. The read/write fields sit in flip-flops: Command, cache line size, latency timer, interrupt line and the implemented base address bits. The identification fields are fixed at elaboration through parameters.

The block holds one to three base address registers. Each is set as either memory or I/O space, with a power-of-two size from 16 bytes to 2 GB. Only the address bits at or above the size are stored. Those same bits are compared against incoming transaction addresses, which gives a per-BAR hit vector. A BAR can hit only when its space enable in the Command register is set and the transaction command is of the matching class. The Command bits, the latency timer and the interrupt line are driven out to the rest of the function.

Top module: `pci_cfg_hdr`

## Requirements
- R1: After reset, Command, cache line size, latency timer, interrupt line and all BAR bases are zero, `cfg_rvalid_o` is low and `bar_hit_o` is all zero.
- R2: Reads return the fixed identification fields: index 0 = {device id, vendor id}; index 2 = {class code, revision}; index 11 = {subsystem id, subsystem vendor id}; index 13 = {24'h0, capability pointer}; index 15 = {max latency, min grant, interrupt pin, interrupt line}.
- R3: Indices 7, 8, 9, 10, 12 and 14 read zero. Status (index 1 bits 31:16), BIST and header type (index 3 bits 31:16) and BARs beyond `NUM_BARS` also read zero. Writes to these locations and to read-only identification fields change nothing that can be read back.
- R4: An access is performed only while `cfg_sel_i` is high. Command code 4'b1010 is a read and 4'b1011 is a write. Any other code, or a deasserted select, causes neither a read response nor a register change.
- R5: On a write, byte enable bit k gates data bits 8k+7:8k. Lanes whose enable is low keep their old value.
- R6: The Command register (index 1 bits 15:0) stores only bits 0 (I/O enable), 1 (memory enable), 2 (bus master), 6 (parity response), 8 (SERR enable) and 10 (interrupt disable). Its other bits read zero.
- R7: After all ones are written to a BAR, it reads back ones above its size and zeros below it. Bit 0 reads 1 for an I/O BAR and 0 for a memory BAR; memory BARs report 32-bit, non-prefetchable type.
- R8: The cache line size is at index 3 bits 7:0, the latency timer at index 3 bits 15:8 and the interrupt line at index 15 bits 7:0. All three are read/write. `latency_timer_o`, `int_line_o` and `command_o` follow the stored values one cycle after the write. With `LAT_TIMER_EN` = 0, the latency timer reads zero.
- R9: For memory commands 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111, a memory BAR hits when Command bit 1 is set and the address bits at or above its size equal its base.
- R10: For I/O commands 4'b0010 and 4'b0011, an I/O BAR hits when Command bit 0 is set and the address bits at or above its size equal its base.
- R11: No BAR hits when `txn_valid_i` is low, when its space enable is clear, when the command is not of its space class, or when the upper address bits differ.
- R12: `cfg_rvalid_o` and `cfg_rdata_o` are valid in exactly the cycle after a read request is sampled, and `cfg_rvalid_o` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sel_i | input | 1 | Configuration access request for this function |
| cfg_cmd_i | input | 4 | Bus command code of the access |
| cfg_idx_i | input | 4 | Dword index into the header |
| cfg_be_i | input | 4 | Byte enables, active high |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data |
| cfg_rvalid_o | output | 1 | Read data valid |
| txn_valid_i | input | 1 | Address phase of a transaction to decode |
| txn_cmd_i | input | 4 | Command code of that transaction |
| txn_addr_i | input | 32 | Address of that transaction |
| bar_hit_o | output | NUM_BARS | One bit per implemented BAR, set on match |
| command_o | output | 16 | Command register contents |
| latency_timer_o | output | 8 | Latency timer value |
| int_line_o | output | 8 | Interrupt line value |

## Verification
The assertions assume that a configuration request lasts a single sampled cycle. They also assume that the index, byte enables and data are stable while it is sampled. The hit checks take the transaction address, command and valid as settled combinational inputs within the cycle. The bench drives every input on the falling edge and puts an idle cycle between configuration accesses. It samples hit outputs one time step after changing the transaction inputs, so each request and each decode is observed on its own.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  // writable Command bits: io, mem, master, parity resp, serr, int disable
  localparam logic [15:0] CMD_WMASK = 16'h0547;

  localparam logic [3:0] IDX_ID      = 4'd0;
  localparam logic [3:0] IDX_STATCMD = 4'd1;
  localparam logic [3:0] IDX_CLASS   = 4'd2;
  localparam logic [3:0] IDX_MISC    = 4'd3;
  localparam logic [3:0] IDX_BAR0    = 4'd4;
  localparam logic [3:0] IDX_SUBSYS  = 4'd11;
  localparam logic [3:0] IDX_CAPP    = 4'd13;
  localparam logic [3:0] IDX_INTR    = 4'd15;

  localparam int unsigned MAX_BARS = 3;

  function automatic logic [31:0] be_to_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic is_mem_cmd(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
           (c == 4'b1110) || (c == 4'b1111);
  endfunction

  function automatic logic is_io_cmd(input logic [3:0] c);
    return (c == 4'b0010) || (c == 4'b0011);
  endfunction

endpackage

// File: rtl/pci_cfg_bar.sv
module pci_cfg_bar
  import pci_cfg_pkg::*;
#(
  parameter bit          IS_IO   = 1'b0,
  parameter int unsigned SZ_LOG2 = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  input  logic        space_en_i,
  input  logic        txn_valid_i,
  input  logic [3:0]  txn_cmd_i,
  input  logic [31:0] txn_addr_i,
  output logic [31:0] rdata_o,
  output logic        hit_o
);

  localparam logic [31:0] AMASK     = ~((32'd1 << SZ_LOG2) - 32'd1);
  localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h0000_0001 : 32'h0000_0000;

  logic [31:0] base_q;
  logic [31:0] wmask;
  logic        cls_ok;

  assign wmask = be_to_mask(be_i) & AMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (wr_en_i) begin
      base_q <= (base_q & ~wmask) | (wdata_i & wmask);
    end
  end

  generate
    if (IS_IO) begin : g_io
      assign cls_ok = is_io_cmd(txn_cmd_i);
    end else begin : g_mem
      assign cls_ok = is_mem_cmd(txn_cmd_i);
    end
  endgenerate

  assign rdata_o = base_q | TYPE_BITS;
  assign hit_o   = txn_valid_i && space_en_i && cls_ok &&
                   ((txn_addr_i & AMASK) == base_q);

endmodule

// File: rtl/pci_cfg_ctrl.sv
module pci_cfg_ctrl
  import pci_cfg_pkg::*;
#(
  parameter bit LAT_TIMER_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  idx_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] command_o,
  output logic [7:0]  cls_o,
  output logic [7:0]  lat_o,
  output logic [7:0]  int_line_o
);

  logic [15:0] cmd_q;
  logic [7:0]  cls_q;
  logic [7:0]  int_line_q;
  logic        wr_cmd, wr_misc, wr_intr;

  assign wr_cmd  = wr_en_i && (idx_i == IDX_STATCMD);
  assign wr_misc = wr_en_i && (idx_i == IDX_MISC);
  assign wr_intr = wr_en_i && (idx_i == IDX_INTR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= '0;
      cls_q      <= '0;
      int_line_q <= '0;
    end else begin
      if (wr_cmd && be_i[0]) cmd_q[7:0]  <= wdata_i[7:0]  & CMD_WMASK[7:0];
      if (wr_cmd && be_i[1]) cmd_q[15:8] <= wdata_i[15:8] & CMD_WMASK[15:8];
      if (wr_misc && be_i[0]) cls_q <= wdata_i[7:0];
      if (wr_intr && be_i[0]) int_line_q <= wdata_i[7:0];
    end
  end

  generate
    if (LAT_TIMER_EN) begin : g_lat
      logic [7:0] lat_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 lat_q <= '0;
        else if (wr_misc && be_i[1]) lat_q <= wdata_i[15:8];
      end
      assign lat_o = lat_q;
    end else begin : g_no_lat
      assign lat_o = '0;
    end
  endgenerate

  assign command_o  = cmd_q;
  assign cls_o      = cls_q;
  assign int_line_o = int_line_q;

endmodule

// File: rtl/pci_cfg_rdmux.sv
module pci_cfg_rdmux
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h5A17,
  parameter logic [23:0] CLASS_CODE = 24'h118000,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [15:0] SUBSYS_VID = 16'hABCD,
  parameter logic [15:0] SUBSYS_ID  = 16'h0042,
  parameter logic [7:0]  CAP_PTR    = 8'h00,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h02,
  parameter logic [7:0]  MAX_LAT    = 8'h08
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_en_i,
  input  logic [3:0]  idx_i,
  input  logic [15:0] command_i,
  input  logic [7:0]  cls_i,
  input  logic [7:0]  lat_i,
  input  logic [7:0]  int_line_i,
  input  logic [31:0] bar_rd_i [MAX_BARS],
  output logic [31:0] rdata_o,
  output logic        rvalid_o
);

  logic [31:0] sel_d;
  logic [31:0] rdata_q;
  logic        rvalid_q;

  always_comb begin
    sel_d = '0;
    case (idx_i)
      IDX_ID:      sel_d = {DEVICE_ID, VENDOR_ID};
      IDX_STATCMD: sel_d = {16'h0000, command_i};
      IDX_CLASS:   sel_d = {CLASS_CODE, REV_ID};
      IDX_MISC:    sel_d = {16'h0000, lat_i, cls_i};
      4'd4:        sel_d = bar_rd_i[0];
      4'd5:        sel_d = bar_rd_i[1];
      4'd6:        sel_d = bar_rd_i[2];
      IDX_SUBSYS:  sel_d = {SUBSYS_ID, SUBSYS_VID};
      IDX_CAPP:    sel_d = {24'h0, CAP_PTR};
      IDX_INTR:    sel_d = {MAX_LAT, MIN_GNT, INT_PIN, int_line_i};
      default:     sel_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= sel_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
  import pci_cfg_pkg::*;
#(
  parameter int unsigned NUM_BARS      = 3,
  parameter logic [2:0]  BAR_IO        = 3'b010,
  parameter int unsigned BAR0_SZ_LOG2  = 12,
  parameter int unsigned BAR1_SZ_LOG2  = 4,
  parameter int unsigned BAR2_SZ_LOG2  = 31,
  parameter bit          LAT_TIMER_EN  = 1'b1,
  parameter logic [15:0] VENDOR_ID     = 16'hABCD,
  parameter logic [15:0] DEVICE_ID     = 16'h5A17,
  parameter logic [23:0] CLASS_CODE    = 24'h118000,
  parameter logic [7:0]  REV_ID        = 8'h03,
  parameter logic [15:0] SUBSYS_VID    = 16'hABCD,
  parameter logic [15:0] SUBSYS_ID     = 16'h0042,
  parameter logic [7:0]  CAP_PTR       = 8'h00,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h02,
  parameter logic [7:0]  MAX_LAT       = 8'h08
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_sel_i,
  input  logic [3:0]          cfg_cmd_i,
  input  logic [3:0]          cfg_idx_i,
  input  logic [3:0]          cfg_be_i,
  input  logic [31:0]         cfg_wdata_i,
  output logic [31:0]         cfg_rdata_o,
  output logic                cfg_rvalid_o,
  input  logic                txn_valid_i,
  input  logic [3:0]          txn_cmd_i,
  input  logic [31:0]         txn_addr_i,
  output logic [NUM_BARS-1:0] bar_hit_o,
  output logic [15:0]         command_o,
  output logic [7:0]          latency_timer_o,
  output logic [7:0]          int_line_o
);

  logic        acc_rd, acc_wr;
  logic [15:0] cmd_w;
  logic [7:0]  cls_w, lat_w, int_line_w;
  logic [31:0] bar_rd [MAX_BARS];
  logic [MAX_BARS-1:0] hit_all;

  assign acc_rd = cfg_sel_i && (cfg_cmd_i == CMD_CFG_RD);
  assign acc_wr = cfg_sel_i && (cfg_cmd_i == CMD_CFG_WR);

  pci_cfg_ctrl #(.LAT_TIMER_EN(LAT_TIMER_EN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (acc_wr),
    .idx_i      (cfg_idx_i),
    .be_i       (cfg_be_i[1:0]),
    .wdata_i    (cfg_wdata_i[15:0]),
    .command_o  (cmd_w),
    .cls_o      (cls_w),
    .lat_o      (lat_w),
    .int_line_o (int_line_w)
  );

  for (genvar b = 0; b < MAX_BARS; b++) begin : g_bar
    if (b < NUM_BARS) begin : g_on
      localparam int unsigned SZ = (b == 0) ? BAR0_SZ_LOG2 :
                                   (b == 1) ? BAR1_SZ_LOG2 : BAR2_SZ_LOG2;
      localparam bit IS_IO = BAR_IO[b];
      logic space_en;
      assign space_en = IS_IO ? cmd_w[0] : cmd_w[1];
      pci_cfg_bar #(.IS_IO(IS_IO), .SZ_LOG2(SZ)) u_bar (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (acc_wr && (cfg_idx_i == IDX_BAR0 + 4'(b))),
        .be_i        (cfg_be_i),
        .wdata_i     (cfg_wdata_i),
        .space_en_i  (space_en),
        .txn_valid_i (txn_valid_i),
        .txn_cmd_i   (txn_cmd_i),
        .txn_addr_i  (txn_addr_i),
        .rdata_o     (bar_rd[b]),
        .hit_o       (hit_all[b])
      );
    end else begin : g_off
      assign bar_rd[b]  = '0;
      assign hit_all[b] = 1'b0;
    end
  end

  pci_cfg_rdmux #(
    .VENDOR_ID (VENDOR_ID),  .DEVICE_ID (DEVICE_ID),
    .CLASS_CODE(CLASS_CODE), .REV_ID    (REV_ID),
    .SUBSYS_VID(SUBSYS_VID), .SUBSYS_ID (SUBSYS_ID),
    .CAP_PTR   (CAP_PTR),    .INT_PIN   (INT_PIN),
    .MIN_GNT   (MIN_GNT),    .MAX_LAT   (MAX_LAT)
  ) u_rdmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (acc_rd),
    .idx_i      (cfg_idx_i),
    .command_i  (cmd_w),
    .cls_i      (cls_w),
    .lat_i      (lat_w),
    .int_line_i (int_line_w),
    .bar_rd_i   (bar_rd),
    .rdata_o    (cfg_rdata_o),
    .rvalid_o   (cfg_rvalid_o)
  );

  assign bar_hit_o       = hit_all[NUM_BARS-1:0];
  assign command_o       = cmd_w;
  assign latency_timer_o = lat_w;
  assign int_line_o      = int_line_w;

endmodule

// File: rtl/pci_cfg_hdr_chk.sv
module pci_cfg_hdr_chk #(
  parameter int unsigned NUM_BARS = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_sel_i,
  input logic [3:0]          cfg_cmd_i,
  input logic [3:0]          cfg_idx_i,
  input logic [31:0]         cfg_rdata_o,
  input logic                cfg_rvalid_o,
  input logic                txn_valid_i,
  input logic [NUM_BARS-1:0] bar_hit_o,
  input logic [15:0]         command_o,
  input logic [7:0]          latency_timer_o,
  input logic [7:0]          int_line_o
);

  logic rd_req, wr_req, unimpl;
  assign rd_req = cfg_sel_i && (cfg_cmd_i == 4'b1010);
  assign wr_req = cfg_sel_i && (cfg_cmd_i == 4'b1011);
  assign unimpl = (cfg_idx_i == 4'd7) || (cfg_idx_i == 4'd8) || (cfg_idx_i == 4'd9) ||
                  (cfg_idx_i == 4'd10) || (cfg_idx_i == 4'd12) || (cfg_idx_i == 4'd14);

  assert_rvalid_after_rd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> cfg_rvalid_o);

  assert_no_stray_rvalid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !cfg_rvalid_o);

  assert_cmd_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req |=> $stable(command_o));

  assert_ctrl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req |=> ($stable(latency_timer_o) && $stable(int_line_o)));

  assert_hit_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bar_hit_o) |-> (txn_valid_i && (command_o[1:0] != 2'b00)));

  assert_unimpl_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && unimpl) |=> (cfg_rdata_o == 32'h0));

endmodule

bind pci_cfg_hdr pci_cfg_hdr_chk #(.NUM_BARS(NUM_BARS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cfg_sel_i       (cfg_sel_i),
  .cfg_cmd_i       (cfg_cmd_i),
  .cfg_idx_i       (cfg_idx_i),
  .cfg_rdata_o     (cfg_rdata_o),
  .cfg_rvalid_o    (cfg_rvalid_o),
  .txn_valid_i     (txn_valid_i),
  .bar_hit_o       (bar_hit_o),
  .command_o       (command_o),
  .latency_timer_o (latency_timer_o),
  .int_line_o      (int_line_o)
);

// File: tb/pci_cfg_hdr_bench.sv
module pci_cfg_hdr_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [3:0]  cfg_cmd = '0;
  logic [3:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        txn_valid = 1'b0;
  logic [3:0]  txn_cmd = '0;
  logic [31:0] txn_addr = '0;
  logic [2:0]  bar_hit;
  logic [15:0] command;
  logic [7:0]  lat;
  logic [7:0]  int_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_hdr u_pci_cfg_hdr (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .cfg_sel_i       (cfg_sel),
    .cfg_cmd_i       (cfg_cmd),
    .cfg_idx_i       (cfg_idx),
    .cfg_be_i        (cfg_be),
    .cfg_wdata_i     (cfg_wdata),
    .cfg_rdata_o     (cfg_rdata),
    .cfg_rvalid_o    (cfg_rvalid),
    .txn_valid_i     (txn_valid),
    .txn_cmd_i       (txn_cmd),
    .txn_addr_i      (txn_addr),
    .bar_hit_o       (bar_hit),
    .command_o       (command),
    .latency_timer_o (lat),
    .int_line_o      (int_line)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cfg_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R4 unexpected read response got=%08h exp=none", cfg_rdata);
      end else begin
        chk(cfg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic access(input logic sel, input logic [3:0] cmd, input logic [3:0] idx,
                        input logic [3:0] be, input logic [31:0] data);
    @(negedge clk);
    cfg_sel = sel; cfg_cmd = cmd; cfg_idx = idx; cfg_be = be; cfg_wdata = data;
    @(negedge clk);
    cfg_sel = 1'b0; cfg_cmd = 4'h0; cfg_be = 4'h0;
  endtask

  task automatic cfg_rd(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    access(1'b1, 4'b1010, idx, 4'h0, 32'h0);
  endtask

  task automatic cfg_wr(input logic [3:0] idx, input logic [3:0] be, input logic [31:0] data);
    access(1'b1, 4'b1011, idx, be, data);
  endtask

  task automatic txn(input logic v, input logic [3:0] c, input logic [31:0] a,
                     input logic [2:0] exp, input string tag);
    @(negedge clk);
    txn_valid = v; txn_cmd = c; txn_addr = a;
    #1;
    chk({29'h0, bar_hit}, {29'h0, exp}, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired got=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({16'h0, command}, 32'h0, "R1 command_o");
    chk({24'h0, lat}, 32'h0, "R1 latency_timer_o");
    chk({24'h0, int_line}, 32'h0, "R1 int_line_o");
    chk({31'h0, cfg_rvalid}, 32'h0, "R1 rvalid");
    cfg_rd(4'd4, 32'h0000_0000, "R1 BAR0 reset");
    cfg_rd(4'd5, 32'h0000_0001, "R1 BAR1 reset (io type bit)");
    cfg_rd(4'd1, 32'h0, "R1 command reg reset");
    txn(1'b1, 4'b0110, 32'h0000_0000, 3'b000, "R1 no hit after reset");

    // R2 identification
    cfg_rd(4'd0, 32'h5A17_ABCD, "R2 device/vendor");
    cfg_rd(4'd2, 32'h1180_0003, "R2 class/rev");
    cfg_rd(4'd11, 32'h0042_ABCD, "R2 subsystem");
    cfg_rd(4'd13, 32'h0000_0000, "R2 cap pointer");
    cfg_rd(4'd15, 32'h0802_0100, "R2 interrupt dword");

    // R3 unimplemented and read-only
    for (int i = 7; i <= 14; i++) begin
      if (i == 11 || i == 13) continue;
      cfg_wr(4'(i), 4'hF, 32'hFFFF_FFFF);
      cfg_rd(4'(i), 32'h0, "R3 unimplemented index");
    end
    cfg_wr(4'd0, 4'hF, 32'h0);
    cfg_rd(4'd0, 32'h5A17_ABCD, "R3 id write ignored");
    cfg_wr(4'd3, 4'hC, 32'hFFFF_0000);
    cfg_rd(4'd3, 32'h0, "R3 bist/header type ignore");

    // R6 command mask, status zero
    cfg_wr(4'd1, 4'hF, 32'hFFFF_FFFF);
    cfg_rd(4'd1, 32'h0000_0547, "R6 command writable mask");
    chk({16'h0, command}, 32'h0000_0547, "R6 command_o");

    // R7 sizing
    cfg_wr(4'd4, 4'hF, 32'hFFFF_FFFF);
    cfg_wr(4'd5, 4'hF, 32'hFFFF_FFFF);
    cfg_wr(4'd6, 4'hF, 32'hFFFF_FFFF);
    cfg_rd(4'd4, 32'hFFFF_F000, "R7 mem 4KB sizing");
    cfg_rd(4'd5, 32'hFFFF_FFF1, "R7 io 16B sizing");
    cfg_rd(4'd6, 32'h8000_0000, "R7 mem 2GB sizing");

    // R5 / R8 byte lanes and control regs
    cfg_wr(4'd3, 4'h1, 32'hA5A5_5A3C);
    cfg_rd(4'd3, 32'h0000_003C, "R5 lane0 only");
    chk({24'h0, lat}, 32'h0, "R5 latency untouched");
    cfg_wr(4'd3, 4'h2, 32'hFFFF_40FF);
    cfg_rd(4'd3, 32'h0000_403C, "R8 latency write");
    chk({24'h0, lat}, 32'h40, "R8 latency_timer_o");
    cfg_wr(4'd15, 4'h1, 32'hFFFF_FF77);
    chk({24'h0, int_line}, 32'h77, "R8 int_line_o");
    cfg_wr(4'd15, 4'hE, 32'h0000_0000);
    cfg_rd(4'd15, 32'h0802_0177, "R8 int dword with line");

    // R4 command codes and select
    access(1'b1, 4'b0110, 4'd3, 4'hF, 32'h0);
    access(1'b0, 4'b1011, 4'd3, 4'hF, 32'h0);
    access(1'b0, 4'b1010, 4'd3, 4'h0, 32'h0);
    access(1'b1, 4'b0111, 4'd1, 4'hF, 32'h0);
    cfg_rd(4'd3, 32'h0000_403C, "R4 misc unchanged");
    chk({16'h0, command}, 32'h0000_0547, "R4 command unchanged");

    // program bases
    cfg_wr(4'd4, 4'hF, 32'h1234_5ABC);
    cfg_wr(4'd5, 4'hF, 32'h0000_C0F7);
    cfg_wr(4'd6, 4'hF, 32'h8000_1234);
    cfg_rd(4'd4, 32'h1234_5000, "R7 BAR0 base low bits dropped");
    cfg_rd(4'd5, 32'h0000_C0F1, "R7 BAR1 base io");
    cfg_rd(4'd6, 32'h8000_0000, "R7 BAR2 base");
    cfg_wr(4'd4, 4'h8, 32'hAB00_0000);
    cfg_rd(4'd4, 32'hAB34_5000, "R5 BAR lane3 only");
    cfg_wr(4'd4, 4'h8, 32'h12FF_FFFF);
    cfg_rd(4'd4, 32'h1234_5000, "R5 BAR restore");

    // R9 R10 R11 decode
    txn(1'b1, 4'b0110, 32'h1234_5ABC, 3'b001, "R9 mem read BAR0");
    txn(1'b1, 4'b1100, 32'h1234_5FFF, 3'b001, "R9 read multiple BAR0 top");
    txn(1'b1, 4'b1111, 32'hFFFF_FFFF, 3'b100, "R9 2GB BAR2");
    txn(1'b1, 4'b0111, 32'h9000_0000, 3'b100, "R9 mem write BAR2");
    txn(1'b1, 4'b0010, 32'h0000_C0FC, 3'b010, "R10 io read BAR1");
    txn(1'b1, 4'b0110, 32'h1234_6000, 3'b000, "R11 address miss");
    txn(1'b1, 4'b0011, 32'h0000_C0E0, 3'b000, "R11 io miss");
    txn(1'b1, 4'b0010, 32'h1234_5000, 3'b000, "R11 io cmd to mem BAR");
    txn(1'b1, 4'b0110, 32'h0000_C0F0, 3'b000, "R11 mem cmd to io BAR");
    txn(1'b0, 4'b0110, 32'h1234_5000, 3'b000, "R11 valid low");
    txn(1'b1, 4'b1010, 32'h1234_5000, 3'b000, "R11 config cmd");
    txn(1'b0, 4'b0000, 32'h0, 3'b000, "R11 idle");

    cfg_wr(4'd1, 4'h1, 32'h0000_0001);
    chk({16'h0, command}, 32'h0000_0501, "R5 command lane0 only");
    txn(1'b1, 4'b0110, 32'h1234_5000, 3'b000, "R11 mem disabled");
    txn(1'b1, 4'b0011, 32'h0000_C0F0, 3'b010, "R10 io still enabled");
    cfg_wr(4'd1, 4'h3, 32'h0000_0002);
    txn(1'b1, 4'b0011, 32'h0000_C0F0, 3'b000, "R11 io disabled");
    txn(1'b1, 4'b0110, 32'h1234_5000, 3'b001, "R9 mem re-enabled");
    txn(1'b0, 4'b0000, 32'h0, 3'b000, "R11 idle end");

    repeat (4) @(negedge clk);
    chk(32'(exp_q.size()), 32'h0, "R12 all reads answered");
    finish_run();
  end

endmodule